// File: doc/BRIEF.md
# Latched Serial-to-Parallel Shift Register

The block takes a serial bit stream into a chain of shift stages and, on a separate storage strobe, moves a snapshot of the whole chain into a holding register that drives a parallel bus. Because the two registers have their own clocks, a new word can be shifted in while the previous word stays steady on the outputs. The parallel bus floats to high impedance under an active-low output enable. A ready-made enable flag and an ungated copy of the data are also provided, for targets that have no internal tri-state buffers.

The last shift stage is brought out as a cascade bit. Several instances can share both clocks and be chained through it into one wider converter. An active-low asynchronous clear empties only the shift stages. Its release is synchronised to the shift clock, so the chain leaves reset cleanly on a shift edge.

Top module: `ssr_latched_s2p`

## Requirements
- R1: On each rising edge of `shift_clk_i`, stage 0 takes `ser_i`, and every stage k takes the old value of stage k-1.
- R2: On each rising edge of `store_clk_i`, all WIDTH shift stages are copied into the storage register. `par_data_o` always shows the storage register, with bit k taken from shift stage k.
- R3: When both clocks rise together, the storage register takes the shift contents from before that edge, so it lags the shift chain by one pulse.
- R4: While `rst_ni` is low, all shift stages are zero, without waiting for a clock. The storage register and `par_data_o` do not change.
- R5: `casc_o` always equals the last shift stage. It is low during clear, and `oe_ni` has no effect on it.
- R6: With `oe_ni` = 1, `par_o` is all high impedance and `par_en_o` = 0. With `oe_ni` = 0, `par_o` equals the storage register and `par_en_o` = 1.
- R7: A clear followed by one storage edge leaves the storage register all zero.
- R8: After `rst_ni` rises, the first SYNC_STAGES (default 2) shift edges leave the chain all zero. The next shift edge captures `ser_i` into stage 0.
- R9: Two instances chained through `casc_o` behave as one 2·WIDTH-stage chain. After 2·WIDTH shifts and one storage edge, the downstream instance holds the first WIDTH bits sent, with the first bit in its top bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk_i | input | 1 | Shift chain clock, rising edge |
| store_clk_i | input | 1 | Storage register clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear of the shift chain |
| ser_i | input | 1 | Serial data in |
| oe_ni | input | 1 | Active-low parallel output enable |
| par_o | output | WIDTH | Tri-state parallel bus |
| par_en_o | output | 1 | High when the parallel bus is driven |
| par_data_o | output | WIDTH | Ungated storage register contents |
| casc_o | output | 1 | Last shift stage, for cascading |

## Verification
On every shift edge, the assertions check the movement of data through the chain: stage 0 takes the serial input, each stage takes its neighbour's old value, and the chain stays empty while the clear release is still being synchronised. On every storage edge they check that the storage register takes a copy of the chain as it was before the edge. Some behaviour can only be shown by the bench's scenarios: the clear leaves the storage untouched, tied clocks produce the one-pulse lag, the cascade bit ignores the enable, and a two-device chain splits a 16-bit word correctly. The bench checks these at the ports against a model it computes itself.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  parameter int unsigned SSR_WIDTH_DEF = 8;
  parameter int unsigned SSR_SYNC_DEF  = 2;

  typedef enum logic {
    OE_DRIVE = 1'b0,
    OE_FLOAT = 1'b1
  } oe_level_e;
endpackage

// File: rtl/ssr_rst_sync.sv
module ssr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  // assert at once, release on the STAGES-th clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o
);
  logic [WIDTH-1:0] stage_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic d;
    if (k == 0) begin : g_head
      assign d = ser_i;
    end else begin : g_body
      assign d = stage_q[k-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[k] <= 1'b0;
      else         stage_q[k] <= d;
    end
  end

  assign stage_o = stage_q;

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stage_q[0] == $past(ser_i)); // R1
  AST_SHIFT_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> stage_q[WIDTH-1:1] == $past(stage_q[WIDTH-2:0])); // R1
endmodule

// File: rtl/ssr_store_latch.sv
module ssr_store_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // no reset: contents undefined until the first storage edge
  always_ff @(posedge clk_i) q_o <= d_i;
endmodule

// File: rtl/ssr_out_drive.sv
module ssr_out_drive
  import ssr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             oe_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] par_o,
  output logic             par_en_o,
  output logic [WIDTH-1:0] par_data_o
);
  assign par_en_o   = (oe_ni == OE_DRIVE);
  assign par_data_o = d_i;
  assign par_o      = par_en_o ? d_i : {WIDTH{1'bz}};
endmodule

// File: rtl/ssr_latched_s2p.sv
module ssr_latched_s2p
  import ssr_pkg::*;
#(
  parameter int unsigned WIDTH       = SSR_WIDTH_DEF,
  parameter int unsigned SYNC_STAGES = SSR_SYNC_DEF
) (
  input  logic             shift_clk_i,
  input  logic             store_clk_i,
  input  logic             rst_ni,
  input  logic             ser_i,
  input  logic             oe_ni,
  output logic [WIDTH-1:0] par_o,
  output logic             par_en_o,
  output logic [WIDTH-1:0] par_data_o,
  output logic             casc_o
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             rst_sync_n;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] store_q;

  ssr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (shift_clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ssr_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk_i   (shift_clk_i),
    .rst_ni  (rst_sync_n),
    .ser_i   (ser_i),
    .stage_o (shift_q)
  );

  ssr_store_latch #(.WIDTH(WIDTH)) u_store (
    .clk_i (store_clk_i),
    .d_i   (shift_q),
    .q_o   (store_q)
  );

  ssr_out_drive #(.WIDTH(WIDTH)) u_out (
    .oe_ni      (oe_ni),
    .d_i        (store_q),
    .par_o      (par_o),
    .par_en_o   (par_en_o),
    .par_data_o (par_data_o)
  );

  assign casc_o = shift_q[LAST];

  AST_HOLD_CLEAR: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    !rst_sync_n |-> shift_q == '0); // R8
  AST_STORE_COPY: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    1'b1 |=> store_q == $past(shift_q)); // R2
endmodule

// File: tb/ssr_latched_s2p_tb.sv
module ssr_latched_s2p_tb;
  localparam int W = 8;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic sh = 1'b0, st = 1'b0, rst_n = 1'b0, ser = 1'b0, oe_n = 1'b0;
  wire [W-1:0] par_a, par_b;
  logic [W-1:0] data_a, data_b;
  logic en_a, en_b, casc_a, casc_b;

  ssr_latched_s2p #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_dut (
    .shift_clk_i(sh), .store_clk_i(st), .rst_ni(rst_n), .ser_i(ser), .oe_ni(oe_n),
    .par_o(par_a), .par_en_o(en_a), .par_data_o(data_a), .casc_o(casc_a));
  ssr_latched_s2p #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_dut_b (
    .shift_clk_i(sh), .store_clk_i(st), .rst_ni(rst_n), .ser_i(casc_a), .oe_ni(oe_n),
    .par_o(par_b), .par_en_o(en_b), .par_data_o(data_b), .casc_o(casc_b));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [2*W-1:0] chain = '0;
  logic [W-1:0] st_a = '0, st_b = '0;
  bit st_valid = 0;
  int hold = SYNC;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] next_chain(input logic [2*W-1:0] c, input logic b);
    return {c[2*W-2:0], b};
  endfunction

  task automatic pulse(input bit do_sh, input bit do_st, input logic b);
    ser = b;
    #2;
    sh = do_sh; st = do_st;
    #4;
    sh = 1'b0; st = 1'b0;
    #2;
    if (do_st) begin
      st_a = chain[W-1:0]; st_b = chain[2*W-1:W]; st_valid = 1;
    end
    if (do_sh) begin
      if (hold > 0) hold--;
      else chain = next_chain(chain, b);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " casc_a"}, {7'd0, casc_a}, {7'd0, chain[W-1]});
    chk({req, " casc_b"}, {7'd0, casc_b}, {7'd0, chain[2*W-1]});
    chk({req, " en"}, {7'd0, en_a}, {7'd0, ~oe_n});
    if (st_valid) begin
      chk({req, " data_a"}, data_a, st_a);
      chk({req, " data_b"}, data_b, st_b);
      if (!oe_n) chk({req, " R6 par_a"}, par_a, st_a);
    end
  endtask

  task automatic do_clear();
    rst_n = 1'b0;
    #3;
    chain = '0; hold = SYNC;
    chk("R4 R5 casc low in clear", {7'd0, casc_a}, 8'd0);
    if (st_valid) chk("R4 storage kept", data_a, st_a);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #3;
    chk("R5 reset casc", {7'd0, casc_a}, 8'd0);
    chk("R4 reset casc_b", {7'd0, casc_b}, 8'd0);
    rst_n = 1'b1;
    #1;
    // R8: two shift edges absorbed after release
    pulse(1, 0, 1'b1);
    pulse(1, 0, 1'b1);
    pulse(0, 1, 1'b0);
    chk("R8 chain empty after sync edges", data_a, 8'h00);
    pulse(1, 0, 1'b1);
    pulse(0, 1, 1'b0);
    chk("R8 first capture", data_a, 8'h01);
    // R1 directed pattern
    for (int i = 0; i < W; i++) pulse(1, 0, (8'hB4 >> (W-1-i)) & 1'b1);
    pulse(0, 1, 1'b0);
    chk("R1 R2 pattern B4", data_a, 8'hB4);
    check_all("R2");
    // R3 tied clocks
    pulse(1, 1, 1'b1);
    chk("R3 lag", data_a, 8'hB4);
    pulse(1, 1, 1'b0);
    chk("R3 lag second", data_a, 8'h69);
    // R6 output gating, R5 cascade unaffected
    oe_n = 1'b1; #1;
    chk("R6 float en", {7'd0, en_a}, 8'd0);
    chk("R5 casc ignores oe", {7'd0, casc_a}, {7'd0, chain[W-1]});
    oe_n = 1'b0; #1;
    chk("R6 drive", par_a, st_a);
    // R4 / R7
    do_clear();
    chk("R4 data kept after clear", data_a, st_a);
    pulse(0, 1, 1'b0);
    chk("R7 zero load", data_a, 8'h00);
    chk("R7 zero load b", data_b, 8'h00);
    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      logic b = 1'($urandom);
      if (op < 5)       pulse(1, 0, b);
      else if (op < 7)  pulse(0, 1, b);
      else if (op < 8)  pulse(1, 1, b);
      else if (op < 9)  begin oe_n = ~oe_n; #1; end
      else if (i % 37 == 0) do_clear();
      else pulse(1, 0, b);
      check_all("R1 R2 R3 random");
    end
    // R9 two-device chain
    oe_n = 1'b0;
    do_clear();
    pulse(1, 0, 1'b0);
    pulse(1, 0, 1'b0);
    for (int i = 0; i < 2*W; i++) pulse(1, 0, (16'hA5C3 >> (2*W-1-i)) & 1'b1);
    pulse(0, 1, 1'b0);
    chk("R9 downstream word", data_b, 8'hA5);
    chk("R9 upstream word", data_a, 8'hC3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule